// File: doc/BRIEF.md
# Coin-Level Candy Release Controller

This block controls a candy dispenser that accepts nickels and dimes. Each coin sensor gives a level that stays high while a coin passes it. The two levels arrive already synchronized to the clock. A Moore state machine samples them on every rising edge. A coin is first held in a "coin present" state while its level is high. It is committed to the running total only when the level drops back to low.

When a coin brings the total to 15 or 20 cents, the machine enters a release state and raises the release output. No change is given for 20 cents. The release output stays high for as long as that last coin's level is high. Once both levels are low again, the machine returns to idle, ready for the next customer.

The inputs follow a single-change discipline: only one coin level moves at a time, and both levels are never high together in normal use. The three state bits are assigned so that every transition flips exactly one bit. Where no direct one-bit path exists, the machine steps through spare codes.

Top module: `vend_coin_ctrl`

## Requirements
- R1: An active-low asynchronous reset `rst_ni` puts the machine in idle with `release_o` low at once, and any partial total is lost.
- R2: Three nickels, each taken high and then low, give exactly one release pulse, raised on the first rising edge that samples the third nickel high.
- R3: A dime followed by a nickel gives exactly one release pulse, raised on the first rising edge that samples the nickel high.
- R4: A nickel followed by a dime reaches 15 cents and gives exactly one release pulse, and a release never rises unless a coin level was high at the preceding edge.
- R5: Two dimes (20 cents) give exactly one release pulse, raised on the first rising edge that samples the second dime high, with no further pulse.
- R6: `release_o` stays high while the completing coin's level stays high, falls on the first rising edge that samples both levels low, and the machine is then idle, so that the next sequence needs a full 15 cents again.
- R7: `release_o` stays low while the committed total plus any coin being sensed is below 15 cents.
- R8: A sample with both levels high (`dime_i`=1, `nickel_i`=1) leaves the state and the total unchanged.
- R9: Every state change flips exactly one state bit. From 5 cents, a dime therefore passes through two transient codes, and `release_o` rises on the third rising edge that samples the dime high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dime_i | input | 1 | Dime sensor level, high while a dime passes |
| nickel_i | input | 1 | Nickel sensor level, high while a nickel passes |
| release_o | output | 1 | Candy release, high in the release state |

## Verification
The four two- or three-coin orders (N-N-N, D-N, N-D, D-D) are each applied with coins held for several cycles. Together they separate the three ways the release state is reached: a one-edge entry from 10 cents by either coin, and the three-edge route from 5 cents through the spare codes. The pulse counts at the end of each order distinguish a correct return to idle from a lingering total. Samples with both levels high are injected both in idle and at 5 cents, which shows that such a sample neither adds a coin nor discards one. A reset taken while the release output is high, followed by a dime and then a nickel, shows that the earlier total is lost.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int unsigned ST_W = 3;

  // Codes are placed on the 3-cube so that every transition is one bit flip.
  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 3'b000,
    ST_N5_HI  = 3'b001,
    ST_C5     = 3'b011,
    ST_C10_HI = 3'b010,
    ST_C10    = 3'b110,
    ST_REL    = 3'b100,
    ST_HOP_A  = 3'b111,
    ST_HOP_B  = 3'b101
  } vend_st_e;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_NICKEL = 2'd1,
    EV_DIME   = 2'd2,
    EV_BOTH   = 2'd3
  } coin_ev_e;
endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
(
  input  logic     dime_i,
  input  logic     nickel_i,
  output coin_ev_e ev_o
);
  always_comb begin
    unique case ({dime_i, nickel_i})
      2'b01:   ev_o = EV_NICKEL;
      2'b10:   ev_o = EV_DIME;
      2'b11:   ev_o = EV_BOTH;
      default: ev_o = EV_NONE;
    endcase
  end
endmodule

// File: rtl/vend_next_state.sv
module vend_next_state
  import vend_pkg::*;
(
  input  vend_st_e cur_i,
  input  coin_ev_e ev_i,
  output vend_st_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i)
      ST_IDLE: begin
        if (ev_i == EV_NICKEL)    nxt_o = ST_N5_HI;
        else if (ev_i == EV_DIME) nxt_o = ST_C10_HI;
      end
      ST_N5_HI:  if (ev_i == EV_NONE) nxt_o = ST_C5;
      ST_C5: begin
        if (ev_i == EV_NICKEL)    nxt_o = ST_C10_HI;
        else if (ev_i == EV_DIME) nxt_o = ST_HOP_A;
      end
      ST_C10_HI: if (ev_i == EV_NONE) nxt_o = ST_C10;
      ST_C10: begin
        if (ev_i == EV_NICKEL || ev_i == EV_DIME) nxt_o = ST_REL;
      end
      ST_REL:    if (ev_i == EV_NONE) nxt_o = ST_IDLE;
      // transient route 011 -> 111 -> 101 -> 100, independent of inputs
      ST_HOP_A:  nxt_o = ST_HOP_B;
      ST_HOP_B:  nxt_o = ST_REL;
      default:   nxt_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
  import vend_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  coin_ev_e ev_i,
  input  vend_st_e nxt_i,
  output vend_st_e state_o
);
  vend_st_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= nxt_i;
  end

  assign state_o = state_q;

  // R9
  one_bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q ^ $past(state_q)) <= 1);

  // R9
  hop_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOP_A) |-> ($past(state_q) == ST_C5));

  // R8
  both_high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_BOTH && state_q != ST_HOP_A && state_q != ST_HOP_B)
      |=> $stable(state_q));
endmodule

// File: rtl/vend_coin_ctrl.sv
module vend_coin_ctrl
  import vend_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dime_i,
  input  logic nickel_i,
  output logic release_o
);
  coin_ev_e ev;
  vend_st_e state, nxt;

  vend_coin_decode u_dec (
    .dime_i   (dime_i),
    .nickel_i (nickel_i),
    .ev_o     (ev)
  );

  vend_next_state u_nxt (
    .cur_i (state),
    .ev_i  (ev),
    .nxt_o (nxt)
  );

  vend_state_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .nxt_i   (nxt),
    .state_o (state)
  );

  assign release_o = (state == ST_REL);

  // R4
  rise_needs_coin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(release_o) |-> $past(dime_i || nickel_i));

  // R6
  fall_needs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(release_o) |-> $past(!dime_i && !nickel_i));

  // R6
  rel_exit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_REL && !dime_i && !nickel_i) |=> (state == ST_IDLE));
endmodule

// File: tb/sim_vend_coin_ctrl.sv
module sim_vend_coin_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dime_i = 1'b0;
  logic nickel_i = 1'b0;
  logic release_o;

  always #2 clk = ~clk;

  vend_coin_ctrl u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .dime_i    (dime_i),
    .nickel_i  (nickel_i),
    .release_o (release_o)
  );

  typedef struct {
    logic  exp;
    string req;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;
  int   checks = 0;
  int   errors = 0;
  int   pulses = 0;
  logic prev_rel = 1'b0;
  bit   done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: one expected release value per clock, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      mon_e = sb.pop_front();
      check(release_o === mon_e.exp, mon_e.req, "release_o",
            int'(release_o), int'(mon_e.exp));
    end
    if (rst_ni && release_o && !prev_rel) pulses++;
    prev_rel = release_o;
  end

  task automatic cyc(bit d, bit n, bit exp, string req);
    @(negedge clk);
    dime_i   = d;
    nickel_i = n;
    sb.push_back('{exp: exp, req: req});
  endtask

  // coin held 4 cycles then cleared 2; lat = edge on which release rises
  task automatic coin(bit is_dime, bit completes, int lat, string req);
    for (int k = 1; k <= 4; k++) cyc(is_dime, !is_dime, completes && (k >= lat), req);
    for (int k = 0; k < 2; k++) cyc(1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic end_seq(int exp_p, string req);
    @(posedge clk);
    #2;
    check(pulses == exp_p, req, "release pulse count", pulses, exp_p);
    pulses = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1;
    check(release_o === 1'b0, "R1", "release_o in reset", int'(release_o), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R2: N,N,N
    coin(1'b0, 1'b0, 1, "R7");
    coin(1'b0, 1'b0, 1, "R7");
    coin(1'b0, 1'b1, 1, "R2");
    end_seq(1, "R2");

    // R3: D,N
    coin(1'b1, 1'b0, 1, "R7");
    coin(1'b0, 1'b1, 1, "R3");
    end_seq(1, "R3");

    // R4 / R9: N,D takes the transient route
    coin(1'b0, 1'b0, 1, "R7");
    coin(1'b1, 1'b1, 3, "R9");
    end_seq(1, "R4");

    // R5: D,D = 20 cents, single pulse
    coin(1'b1, 1'b0, 1, "R7");
    coin(1'b1, 1'b1, 1, "R5");
    end_seq(1, "R5");

    // R6: machine is idle again, a lone dime must not release
    coin(1'b1, 1'b0, 1, "R6");
    coin(1'b1, 1'b1, 1, "R6");
    end_seq(1, "R6");

    // R8: both high in idle adds nothing
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 1'b0, "R8");
    cyc(1'b0, 1'b0, 1'b0, "R8");
    coin(1'b0, 1'b0, 1, "R8");
    coin(1'b0, 1'b0, 1, "R8");
    coin(1'b0, 1'b1, 1, "R8");
    end_seq(1, "R8");

    // R8: both high at 5 cents keeps the 5 cents
    coin(1'b0, 1'b0, 1, "R8");
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 1'b0, "R8");
    cyc(1'b0, 1'b0, 1'b0, "R8");
    coin(1'b1, 1'b1, 3, "R8");
    end_seq(1, "R8");

    // R1: reset while releasing, then the old total is gone
    coin(1'b1, 1'b0, 1, "R1");
    cyc(1'b0, 1'b1, 1'b1, "R1");
    end_seq(1, "R1");
    @(negedge clk);
    rst_ni   = 1'b0;
    nickel_i = 1'b0;
    #1;
    check(release_o === 1'b0, "R1", "release_o after async reset", int'(release_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    prev_rel = 1'b0;
    coin(1'b1, 1'b0, 1, "R1");
    coin(1'b0, 1'b1, 1, "R1");
    end_seq(1, "R1");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule